// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a small programmable logic device. Eighteen logic inputs enter an AND plane both as they are and inverted, which makes 36 literal columns. Seventy-four product terms each take the AND of the literals selected for them. A fixed OR plane then combines those terms into eight sums. The same plane also supplies eight per-output enable terms, one global asynchronous-clear term and one global synchronous-preset term. The output cells that consume these signals are outside this block.

The selection pattern is a 74 x 36 bit configuration memory, loaded serially before use. While the load strobe is high, each rising edge of the configuration clock shifts one bit into the memory. Once loading has finished, every output is a purely combinational function of the inputs.

A three-state sequencer sets when the array may drive its outputs:
- **LD_EMPTY** is entered on reset.
- **LD_SHIFT** is entered by the transition *start_load*, which occurs when the strobe is high at a clock edge in either of the other states.
- **LD_ACTIVE** is entered by the transition *finish_load*, which occurs when the strobe is low at a clock edge while in LD_SHIFT.

LD_EMPTY stays where it is while the strobe is low. LD_ACTIVE stays where it is until the strobe rises again. Outputs are forced to zero unless the sequencer is in LD_ACTIVE and the strobe is low.

Top module: `pla_core`

## Requirements
- R1: After reset is asserted, and until a load has been completed, every output (sum, enable, clear, preset) is 0.
- R2: While cfg_load is 1, each rising cfg_clk edge shifts cfg_data in. After 2664 shifts, the bit shifted in at position b (counting from 0) sits at term b/36, column b%36. While cfg_load is 0, the memory keeps its contents.
- R3: Column 2i carries input bit i unchanged and column 2i+1 carries its complement, for i in 0..17.
- R4: A product term is the AND of every column whose configuration bit is 1. A term with no bits set is true.
- R5: A term with every bit set (which includes at least one input together with its complement) is false, so it has no effect on its sum.
- R6: sum_o[k] is the OR of terms 9k to 9k+7.
- R7: oe_o[k] equals term 9k+8. clr_o equals term 72 and preset_o equals term 73.
- R8: While cfg_load is 1, all outputs are 0 in the same cycle. After cfg_load falls, the array drives its outputs starting at the first rising cfg_clk edge that sees cfg_load low.
- R9: Once configured, the outputs follow in_vec with no clock edge in between.
- R10: A new load replaces the whole previous pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset of the load sequencer |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_load | input | 1 | Load strobe; shifting happens and outputs are silenced while it is high |
| cfg_data | input | 1 | Serial configuration bit |
| in_vec | input | 18 | Logic inputs: dedicated inputs and fed-back cell signals |
| sum_o | output | 8 | Sum-of-products results, one per output cell |
| oe_o | output | 8 | Per-output enable terms |
| clr_o | output | 1 | Global asynchronous-clear term |
| preset_o | output | 1 | Global synchronous-preset term |

## Verification
Two things can happen in the same cycle: the array evaluating live inputs, and the start of a new load. The bench sets the inputs so the outputs are non-zero under an active pattern, then raises cfg_load between clock edges. The outputs must drop to zero at once, before any shift edge. The same race at the other end of a load is checked as well: cfg_load falls and the inputs are already set, and the outputs must stay dark until the next edge and then match a model computed from the pattern the bench shifted in.

// File: rtl/pla_pkg.sv
package pla_pkg;

    localparam int unsigned PLA_INPUTS        = 18;
    localparam int unsigned PLA_OUTPUTS       = 8;
    localparam int unsigned PLA_TERMS_PER_OUT = 8;

    typedef enum logic [1:0] {
        LD_EMPTY  = 2'd0,
        LD_SHIFT  = 2'd1,
        LD_ACTIVE = 2'd2
    } ld_state_t;

    function automatic int unsigned pla_term_count(input int unsigned outs,
                                                   input int unsigned per_out);
        return outs * (per_out + 1) + 2;
    endfunction

endpackage

// File: rtl/pla_cfg_loader.sv
module pla_cfg_loader
    import pla_pkg::*;
#(
    parameter int unsigned N_BITS = 2664
) (
    input  logic              rst_n,
    input  logic              cfg_clk,
    input  logic              cfg_load,
    input  logic              cfg_data,
    output logic [N_BITS-1:0] conn_o,
    output logic              live_o
);

    ld_state_t         state_q;
    ld_state_t         state_d;
    logic [N_BITS-1:0] chain_q;

    // state register
    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: start_load, finish_load
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_EMPTY:  if (cfg_load)  state_d = LD_SHIFT;
            LD_SHIFT:  if (!cfg_load) state_d = LD_ACTIVE;
            LD_ACTIVE: if (cfg_load)  state_d = LD_SHIFT;
            default:                  state_d = LD_EMPTY;
        endcase
    end

    // configuration shift chain; first bit shifted ends at index 0
    always_ff @(posedge cfg_clk) begin
        if (cfg_load) begin
            chain_q <= {cfg_data, chain_q[N_BITS-1:1]};
        end
    end

    // outputs
    always_comb begin
        conn_o = chain_q;
        live_o = (state_q == LD_ACTIVE) && !cfg_load;
    end

    AST_SHIFT_ENTRY: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_load |=> (chain_q[N_BITS-1] == $past(cfg_data))); // R2

    AST_HOLD_IDLE: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !cfg_load |=> $stable(chain_q)); // R2

    AST_FINISH_LOAD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (state_q == LD_SHIFT && !cfg_load) |=> (state_q == LD_ACTIVE)); // R8

endmodule

// File: rtl/pla_term.sv
module pla_term #(
    parameter int unsigned N_COL = 36
) (
    input  logic [N_COL-1:0] conn_i,
    input  logic [N_COL-1:0] lit_i,
    output logic             term_o
);

    localparam int unsigned N_PAIR = N_COL / 2;

    logic [N_PAIR-1:0] pair_both;

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        assign pair_both[p] = conn_i[2*p] & conn_i[2*p+1];
    end

    // an unconnected column contributes a 1; an empty term is true
    assign term_o = &(lit_i | ~conn_i);

    always_comb begin
        if (|pair_both) begin
            AST_FULL_TERM_FALSE: assert (!term_o); // R5
        end
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int unsigned N_OUT = 8,
    parameter int unsigned TPO   = 8,
    parameter int unsigned N_TERM = N_OUT * (TPO + 1) + 2
) (
    input  logic [N_TERM-1:0] terms_i,
    input  logic              live_i,
    output logic [N_OUT-1:0]  sum_o,
    output logic [N_OUT-1:0]  oe_o,
    output logic              clr_o,
    output logic              preset_o
);

    localparam int unsigned GROUP   = TPO + 1;
    localparam int unsigned CLR_T   = N_OUT * GROUP;
    localparam int unsigned PRESET_T = CLR_T + 1;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [TPO-1:0] grp;
        assign grp      = terms_i[k*GROUP +: TPO];
        assign sum_o[k] = live_i & (|grp);
        assign oe_o[k]  = live_i & terms_i[k*GROUP + TPO];
    end

    assign clr_o    = live_i & terms_i[CLR_T];
    assign preset_o = live_i & terms_i[PRESET_T];

endmodule

// File: rtl/pla_core.sv
module pla_core
    import pla_pkg::*;
#(
    parameter int unsigned N_IN  = PLA_INPUTS,
    parameter int unsigned N_OUT = PLA_OUTPUTS,
    parameter int unsigned TPO   = PLA_TERMS_PER_OUT
) (
    input  logic             rst_n,
    input  logic             cfg_clk,
    input  logic             cfg_load,
    input  logic             cfg_data,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] sum_o,
    output logic [N_OUT-1:0] oe_o,
    output logic             clr_o,
    output logic             preset_o
);

    localparam int unsigned N_COL  = 2 * N_IN;
    localparam int unsigned N_TERM = pla_term_count(N_OUT, TPO);
    localparam int unsigned N_BITS = N_TERM * N_COL;

    logic [N_BITS-1:0] conn;
    logic              live;
    logic [N_COL-1:0]  lits;
    logic [N_TERM-1:0] terms;

    pla_cfg_loader #(.N_BITS(N_BITS)) i_loader (
        .rst_n    (rst_n),
        .cfg_clk  (cfg_clk),
        .cfg_load (cfg_load),
        .cfg_data (cfg_data),
        .conn_o   (conn),
        .live_o   (live)
    );

    // literal columns: even = true, odd = complement
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]   = in_vec[i];
        assign lits[2*i+1] = ~in_vec[i];
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        pla_term #(.N_COL(N_COL)) i_term (
            .conn_i (conn[t*N_COL +: N_COL]),
            .lit_i  (lits),
            .term_o (terms[t])
        );
    end

    pla_or_plane #(.N_OUT(N_OUT), .TPO(TPO), .N_TERM(N_TERM)) i_or (
        .terms_i  (terms),
        .live_i   (live),
        .sum_o    (sum_o),
        .oe_o     (oe_o),
        .clr_o    (clr_o),
        .preset_o (preset_o)
    );

    AST_DARK_DURING_LOAD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_load |-> (sum_o == '0 && oe_o == '0 && !clr_o && !preset_o)); // R8

    AST_SILENT_AFTER_RESET: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        ($past(!rst_n) && !cfg_load) |-> (sum_o == '0 && oe_o == '0 && !clr_o && !preset_o)); // R1

endmodule

// File: tb/test_pla_core.sv
module test_pla_core;

    localparam int NI = 18;
    localparam int NC = 36;
    localparam int NT = 74;
    localparam int NB = NT * NC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic          cfg_data = 1'b0;
    logic [NI-1:0] in_vec = '0;
    logic [7:0]    sum_o;
    logic [7:0]    oe_o;
    logic          clr_o;
    logic          preset_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [NC-1:0] cfg_m [NT];
    bit   [31:0]   seed = 32'h1357_9bdf;

    always #10 clk = ~clk;

    pla_core i_pla_core (
        .rst_n    (rst_n),
        .cfg_clk  (clk),
        .cfg_load (cfg_load),
        .cfg_data (cfg_data),
        .in_vec   (in_vec),
        .sum_o    (sum_o),
        .oe_o     (oe_o),
        .clr_o    (clr_o),
        .preset_o (preset_o)
    );

    function automatic bit [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic logic term_val(input int t, input logic [NI-1:0] iv);
        logic v = 1'b1;
        for (int c = 0; c < NC; c++) begin
            if (cfg_m[t][c]) v &= (c % 2 == 0) ? iv[c/2] : ~iv[c/2];
        end
        return v;
    endfunction

    // bundle layout: {preset, clr, oe[7:0], sum[7:0]}
    function automatic logic [17:0] model(input logic [NI-1:0] iv);
        logic [7:0] s = '0;
        logic [7:0] e = '0;
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 8; j++) s[k] |= term_val(9*k + j, iv);
            e[k] = term_val(9*k + 8, iv);
        end
        return {term_val(73, iv), term_val(72, iv), e, s};
    endfunction

    task automatic chk(input string req, input logic [17:0] exp);
        logic [17:0] act;
        act = {preset_o, clr_o, oe_o, sum_o};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [NI-1:0] iv);
        in_vec = iv;
        #2;
        chk(req, model(iv));
    endtask

    task automatic load_cfg(input bit probe);
        @(negedge clk);
        cfg_load = 1'b1;
        for (int b = 0; b < NB; b++) begin
            cfg_data = cfg_m[b / NC][b % NC];
            if (probe && (b == 0 || b == NB / 2)) begin
                #2;
                chk("R8 outputs dark while shifting", 18'h0);
            end
            @(negedge clk);
        end
        cfg_load = 1'b0;
        if (probe) begin
            #2;
            chk("R8 still dark before activating edge", 18'h0);
        end
        @(negedge clk);
    endtask

    task automatic fill(input logic [NC-1:0] v);
        for (int t = 0; t < NT; t++) cfg_m[t] = v;
    endtask

    task automatic set_directed();
        fill('1);
        for (int k = 0; k < 8; k++) begin
            cfg_m[9*k] = '0;
            cfg_m[9*k][2*k] = 1'b1;
            cfg_m[9*k][2*(k+8)+1] = 1'b1;
            cfg_m[9*k+8] = '0;
            cfg_m[9*k+8][(k % 2 == 0) ? 32 : 33] = 1'b1;
        end
        cfg_m[72] = '0; cfg_m[72][34] = 1'b1; cfg_m[72][0] = 1'b1;
        cfg_m[73] = '0; cfg_m[73][35] = 1'b1; cfg_m[73][3] = 1'b1;
    endtask

    task automatic t_reset();
        for (int n = 0; n < 4; n++) begin
            in_vec = 18'(rnd());
            @(negedge clk);
            #2;
            chk("R1 dark after reset before any load", 18'h0);
        end
    endtask

    task automatic t_all_connected();
        fill('1);
        load_cfg(1'b0);
        apply("R5 fully connected terms false", 18'h3ffff);
        apply("R5 fully connected terms false", 18'h0);
        apply("R5 fully connected terms false", 18'h2a5c3);
    endtask

    task automatic t_empty();
        fill('0);
        load_cfg(1'b0);
        in_vec = 18'h12345;
        #2;
        chk("R4 empty terms true", 18'h3ffff);
        in_vec = 18'h0;
        #2;
        chk("R4 empty terms true", 18'h3ffff);
    endtask

    task automatic t_directed();
        set_directed();
        load_cfg(1'b0);
        in_vec = 18'h00001;
        #2;
        chk("R2 R3 R6 R7 directed literal value", 18'h2aa01);
        apply("R3 R6 directed", 18'h000ff);
        apply("R3 R6 directed", 18'h0ff00);
        apply("R7 enable and clear terms", 18'h30001);
        apply("R7 enable and clear terms", 18'h10000);
        // R9: inputs change inside half a period, no edge in between
        @(negedge clk);
        apply("R9 follows inputs without clock", 18'h00055);
        apply("R9 follows inputs without clock", 18'h000aa);
        apply("R9 follows inputs without clock", 18'h20002);
    endtask

    task automatic t_random();
        for (int r = 0; r < 2; r++) begin
            for (int t = 0; t < NT; t++)
                for (int c = 0; c < NC; c++) cfg_m[t][c] = ((rnd() & 32'hf) == 0);
            load_cfg(1'b0);
            for (int n = 0; n < 30; n++) apply("R4 R6 random pattern", 18'(rnd()));
        end
    endtask

    task automatic t_load_gate();
        set_directed();
        load_cfg(1'b0);
        in_vec = 18'h00001;
        #2;
        chk("R8 active before reload", 18'h2aa01);
        load_cfg(1'b1);
        #2;
        chk("R8 active after load ends", 18'h2aa01);
    endtask

    task automatic t_reload();
        set_directed();
        load_cfg(1'b0);
        apply("R10 first pattern", 18'h000ff);
        fill('1);
        load_cfg(1'b0);
        in_vec = 18'h000ff;
        #2;
        chk("R10 second pattern replaces first", 18'h0);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        fill('0);
        #2;
        chk("R1 reset silences active array", 18'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk("R1 stays dark after reset without load", 18'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_connected();
        t_empty();
        t_directed();
        t_random();
        t_load_gate();
        t_reload();
        t_reset_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule